// File: doc/BRIEF.md
# MMU Configuration Register Bank

This block is the small register file through which a processor configures its memory management unit. It sits on the core's auxiliary-register bus and stores two 64-bit root pointers for the page-table walker. It also stores a control word, a translation-control word and a fault status word, and it answers a fixed build word. A write-only command port accepts TLB maintenance codes. The walker and the TLB live elsewhere. This bank gives them the enable bit, the mode bit, both root pointers and the two address-half size fields. It also gives them a one-cycle `flush_req` pulse whenever a translation-relevant setting really changes or an invalidate command arrives.

Reads are combinational from the stored values. Each root pointer can be written whole through its base address. It can also be written through a high-word alias that replaces only its upper half. The walker loads the fault status word through a dedicated port. A bus write to that word is dropped and reported with the one-cycle `wr_err` pulse.

Each pulse output is driven by a two-state machine. PULSE_IDLE goes to PULSE_FIRE when a trigger is seen. PULSE_FIRE stays in PULSE_FIRE on a fresh trigger and returns to PULSE_IDLE otherwise. The output is high exactly while the machine is in PULSE_FIRE.

Top module: `mmu_cfg_regbank`

## Requirements
- R1: After reset every stored register reads zero, `mmu_en` and `user_kernel_ctl` are 0, and `flush_req` and `wr_err` are 0.
- R2: Control bit 0 drives `mmu_en` and control bit 1 drives `user_kernel_ctl`. A `disable_req` pulse clears only control bit 0 and raises no flush.
- R3: A full write to a root pointer (address 0 or 2) or to the control word (address 4) makes `flush_req` high in the cycle after the write only if the written value differs from the stored one.
- R4: A write to a high-word alias (address 1 or 3) sets bits 63:32 of that root pointer to `reg_wdata[31:0]` and keeps bits 31:0. It flushes only if the new high word differs from the old one.
- R5: Reading a root pointer's base address returns all 64 bits. Reading its high-word alias returns bits 63:32 of that pointer in `reg_rdata[31:0]`, with the upper 32 bits zero.
- R6: The build word (address 7) always reads 0x0620000A: version 6 in bits 31:24, type 1 at bit 21, DTLB code 2 in bits 2:0, ITLB code 1 at bit 3, other fields zero. Writes to it change nothing.
- R7: A write to the command port (address 8) with `reg_wdata[7:0]` equal to 1, 3, 4, 5 or 6 flushes. Code 2, or any other code, has no effect. The port reads zero.
- R8: A write to the translation-control word (address 5) never flushes. `half0_size` shows its bits 4:0 and `half1_size` shows its bits 20:16.
- R9: A bus write to the fault status word (address 6) leaves it unchanged and raises `wr_err` for exactly the next cycle. `walker_fault_we` loads it from `walker_fault_data`.
- R10: Each triggering write gives `flush_req` for exactly one cycle. Triggering writes in consecutive cycles give `flush_req` in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 4 | Register select (0 root0, 1 root0 high, 2 root1, 3 root1 high, 4 control, 5 translation control, 6 fault, 7 build, 8 command) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| disable_req | input | 1 | Clears the enable bit |
| walker_fault_we | input | 1 | Walker load strobe for fault status |
| walker_fault_data | input | 64 | Walker fault status value |
| mmu_en | output | 1 | Translation enable |
| user_kernel_ctl | output | 1 | User/kernel mode control bit |
| root0_ptr | output | 64 | Root pointer for the lower address half |
| root1_ptr | output | 64 | Root pointer for the upper address half |
| half0_size | output | 5 | Lower-half size field |
| half1_size | output | 5 | Upper-half size field |
| flush_req | output | 1 | One-cycle TLB flush request |
| wr_err | output | 1 | One-cycle illegal-write flag |

## Verification
The bench builds the bank with its defaults: 64-bit data, 32-bit control words and 5-bit size fields. With these values the high-word alias splits the pointer at bit 32. A high-alias write can therefore carry garbage in `reg_wdata[63:32]` to show that those bits are dropped. It can also repeat an unchanged upper half to show that no flush is raised. The 8-bit command field lets the bench walk every defined code and the unused codes 0 and 7 in one table.

// File: rtl/mmu_cfg_pkg.sv
package mmu_cfg_pkg;

    localparam int ADDR_W = 4;
    localparam int CMD_W  = 8;

    localparam logic [ADDR_W-1:0] A_ROOT0    = 4'd0;
    localparam logic [ADDR_W-1:0] A_ROOT0_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_ROOT1    = 4'd2;
    localparam logic [ADDR_W-1:0] A_ROOT1_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd4;
    localparam logic [ADDR_W-1:0] A_XLATE    = 4'd5;
    localparam logic [ADDR_W-1:0] A_FAULT    = 4'd6;
    localparam logic [ADDR_W-1:0] A_BUILD    = 4'd7;
    localparam logic [ADDR_W-1:0] A_CMD      = 4'd8;

    localparam logic [CMD_W-1:0] CMD_INV_ALL    = 8'd1;
    localparam logic [CMD_W-1:0] CMD_READ       = 8'd2;
    localparam logic [CMD_W-1:0] CMD_INV_ASID   = 8'd3;
    localparam logic [CMD_W-1:0] CMD_INV_ADDR   = 8'd4;
    localparam logic [CMD_W-1:0] CMD_INV_RGN    = 8'd5;
    localparam logic [CMD_W-1:0] CMD_INV_RGN_AS = 8'd6;

    localparam int BLD_VERSION = 6;
    localparam int BLD_TYPE    = 1;
    localparam int BLD_L2TLB   = 0;
    localparam int BLD_XCACHE  = 0;
    localparam int BLD_ITLB    = 1;
    localparam int BLD_DTLB    = 2;

    function automatic logic [31:0] build_word();
        logic [31:0] w;
        w = '0;
        w[31:24] = 8'(BLD_VERSION);
        w[21]    = 1'(BLD_TYPE);
        w[9]     = 1'(BLD_L2TLB);
        w[6]     = 1'(BLD_XCACHE);
        w[3]     = 1'(BLD_ITLB);
        w[2:0]   = 3'(BLD_DTLB);
        return w;
    endfunction

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_FIRE = 1'b1
    } pulse_st_e;

endpackage

// File: rtl/mmu_cfg_rootptr.sv
module mmu_cfg_rootptr #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_full_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] value_o,
    output logic              changed_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (wr_full_i) begin
            value_q <= wdata_i;
        end else if (wr_hi_i) begin
            value_q[DATA_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
        end
    end

    always_comb begin
        changed_o = 1'b0;
        if (wr_full_i && (wdata_i != value_q)) begin
            changed_o = 1'b1;
        end
        if (wr_hi_i && (wdata_i[HALF_W-1:0] != value_q[DATA_W-1:HALF_W])) begin
            changed_o = 1'b1;
        end
    end

    assign value_o = value_q;

    assert_hi_keeps_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_full_i) |=> (value_o[HALF_W-1:0] == $past(value_o[HALF_W-1:0])));

    assert_root_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_full_i && !wr_hi_i) |=> $stable(value_o));

endmodule

// File: rtl/mmu_cfg_cmd_decode.sv
module mmu_cfg_cmd_decode
    import mmu_cfg_pkg::*;
(
    input  logic             valid_i,
    input  logic [CMD_W-1:0] code_i,
    output logic             flush_o
);
    always_comb begin
        flush_o = 1'b0;
        if (valid_i) begin
            case (code_i)
                CMD_INV_ALL,
                CMD_INV_ASID,
                CMD_INV_ADDR,
                CMD_INV_RGN,
                CMD_INV_RGN_AS: flush_o = 1'b1;
                CMD_READ:       flush_o = 1'b0;
                default:        flush_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mmu_cfg_pulse.sv
module mmu_cfg_pulse
    import mmu_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);
    pulse_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE: state_d = trig_i ? PULSE_FIRE : PULSE_IDLE;
            PULSE_FIRE: state_d = trig_i ? PULSE_FIRE : PULSE_IDLE;
            default:    state_d = PULSE_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == PULSE_FIRE);
    end

    assert_pulse_after_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> pulse_o);

    assert_pulse_needs_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(trig_i));

endmodule

// File: rtl/mmu_cfg_regbank.sv
module mmu_cfg_regbank
    import mmu_cfg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CTRL_W = 32,
    parameter int SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              disable_req,
    input  logic              walker_fault_we,
    input  logic [DATA_W-1:0] walker_fault_data,
    output logic              mmu_en,
    output logic              user_kernel_ctl,
    output logic [DATA_W-1:0] root0_ptr,
    output logic [DATA_W-1:0] root1_ptr,
    output logic [SIZE_W-1:0] half0_size,
    output logic [SIZE_W-1:0] half1_size,
    output logic              flush_req,
    output logic              wr_err
);
    localparam int HALF_W   = DATA_W / 2;
    localparam int N_ROOT   = 2;
    localparam int HI_SHIFT = CTRL_W / 2;

    logic [DATA_W-1:0] root_q  [N_ROOT];
    logic [N_ROOT-1:0] root_chg;

    for (genvar gi = 0; gi < N_ROOT; gi++) begin : g_root
        logic wr_full, wr_hi;
        assign wr_full = reg_wr && (reg_addr == A_ROOT0 + ADDR_W'(2 * gi));
        assign wr_hi   = reg_wr && (reg_addr == A_ROOT0_HI + ADDR_W'(2 * gi));
        mmu_cfg_rootptr #(.DATA_W(DATA_W)) u_root (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_full_i (wr_full),
            .wr_hi_i   (wr_hi),
            .wdata_i   (reg_wdata),
            .value_o   (root_q[gi]),
            .changed_o (root_chg[gi])
        );
    end

    logic [CTRL_W-1:0] ctrl_q, xlate_q;
    logic [DATA_W-1:0] fault_q;
    logic ctrl_wr, xlate_wr, fault_bus_wr, cmd_wr, ctrl_chg, cmd_flush, flush_trig;

    assign ctrl_wr      = reg_wr && (reg_addr == A_CTRL);
    assign xlate_wr     = reg_wr && (reg_addr == A_XLATE);
    assign fault_bus_wr = reg_wr && (reg_addr == A_FAULT);
    assign cmd_wr       = reg_wr && (reg_addr == A_CMD);
    assign ctrl_chg     = ctrl_wr && (reg_wdata[CTRL_W-1:0] != ctrl_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            xlate_q <= '0;
            fault_q <= '0;
        end else begin
            if (ctrl_wr)         ctrl_q  <= reg_wdata[CTRL_W-1:0];
            if (disable_req)     ctrl_q[0] <= 1'b0;
            if (xlate_wr)        xlate_q <= reg_wdata[CTRL_W-1:0];
            if (walker_fault_we) fault_q <= walker_fault_data;
        end
    end

    mmu_cfg_cmd_decode u_cmd (
        .valid_i (cmd_wr),
        .code_i  (reg_wdata[CMD_W-1:0]),
        .flush_o (cmd_flush)
    );

    assign flush_trig = (|root_chg) || ctrl_chg || cmd_flush;

    mmu_cfg_pulse u_flush_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (flush_trig),
        .pulse_o (flush_req)
    );

    mmu_cfg_pulse u_err_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (fault_bus_wr),
        .pulse_o (wr_err)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ROOT0:    reg_rdata = root_q[0];
            A_ROOT0_HI: reg_rdata = DATA_W'(root_q[0][DATA_W-1:HALF_W]);
            A_ROOT1:    reg_rdata = root_q[1];
            A_ROOT1_HI: reg_rdata = DATA_W'(root_q[1][DATA_W-1:HALF_W]);
            A_CTRL:     reg_rdata = DATA_W'(ctrl_q);
            A_XLATE:    reg_rdata = DATA_W'(xlate_q);
            A_FAULT:    reg_rdata = fault_q;
            A_BUILD:    reg_rdata = DATA_W'(build_word());
            default:    reg_rdata = '0;
        endcase
    end

    assign mmu_en          = ctrl_q[0];
    assign user_kernel_ctl = ctrl_q[1];
    assign root0_ptr       = root_q[0];
    assign root1_ptr       = root_q[1];
    assign half0_size      = xlate_q[SIZE_W-1:0];
    assign half1_size      = xlate_q[HI_SHIFT +: SIZE_W];

    assert_disable_clears_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disable_req |=> !mmu_en);

    assert_disable_keeps_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_req && !reg_wr) |=> $stable(user_kernel_ctl));

    assert_fault_bus_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_bus_wr && !walker_fault_we) |=> $stable(fault_q));

    assert_xlate_no_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_wr) |=> !flush_req);

    assert_read_cmd_no_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[CMD_W-1:0] == CMD_READ) |=> !flush_req);

endmodule

// File: tb/mmu_cfg_regbank_tb.sv
module mmu_cfg_regbank_tb;
    import mmu_cfg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        disable_req = 1'b0;
    logic        walker_fault_we = 1'b0;
    logic [63:0] walker_fault_data = '0;
    logic        mmu_en, user_kernel_ctl, flush_req, wr_err;
    logic [63:0] root0_ptr, root1_ptr;
    logic [4:0]  half0_size, half1_size;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mmu_cfg_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .disable_req(disable_req),
        .walker_fault_we(walker_fault_we), .walker_fault_data(walker_fault_data),
        .mmu_en(mmu_en), .user_kernel_ctl(user_kernel_ctl),
        .root0_ptr(root0_ptr), .root1_ptr(root1_ptr),
        .half0_size(half0_size), .half1_size(half1_size),
        .flush_req(flush_req), .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // waddr, wdata, exp_flush, raddr, exp_rdata
    localparam int NV = 21;
    localparam logic [136:0] VEC [NV] = '{
        {4'd0, 64'h0000_1234_5678_9000, 1'b1, 4'd0, 64'h0000_1234_5678_9000},
        {4'd0, 64'h0000_1234_5678_9000, 1'b0, 4'd0, 64'h0000_1234_5678_9000},
        {4'd1, 64'h0000_0000_0000_ABCD, 1'b1, 4'd0, 64'h0000_ABCD_5678_9000},
        {4'd1, 64'hFFFF_FFFF_0000_ABCD, 1'b0, 4'd1, 64'h0000_0000_0000_ABCD},
        {4'd2, 64'hFFFF_8000_0000_0000, 1'b1, 4'd2, 64'hFFFF_8000_0000_0000},
        {4'd3, 64'h0000_0000_FFFF_8000, 1'b0, 4'd3, 64'h0000_0000_FFFF_8000},
        {4'd4, 64'h0000_0000_0000_0003, 1'b1, 4'd4, 64'h0000_0000_0000_0003},
        {4'd4, 64'h0000_0000_0000_0003, 1'b0, 4'd4, 64'h0000_0000_0000_0003},
        {4'd5, 64'h0000_0000_0019_0010, 1'b0, 4'd5, 64'h0000_0000_0019_0010},
        {4'd8, 64'h0000_0000_0000_0001, 1'b1, 4'd8, 64'h0},
        {4'd8, 64'h0000_0000_0000_0002, 1'b0, 4'd7, 64'h0000_0000_0620_000A},
        {4'd8, 64'h0000_0000_0000_0003, 1'b1, 4'd8, 64'h0},
        {4'd8, 64'h0000_0000_0000_0004, 1'b1, 4'd8, 64'h0},
        {4'd8, 64'h0000_0000_0000_0005, 1'b1, 4'd8, 64'h0},
        {4'd8, 64'h0000_0000_0000_0006, 1'b1, 4'd8, 64'h0},
        {4'd8, 64'h0000_0000_0000_0007, 1'b0, 4'd2, 64'hFFFF_8000_0000_0000},
        {4'd8, 64'h0000_0000_0000_0000, 1'b0, 4'd0, 64'h0000_ABCD_5678_9000},
        {4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd7, 64'h0000_0000_0620_000A},
        {4'd6, 64'h0000_0000_0000_0055, 1'b0, 4'd6, 64'h0},
        {4'd2, 64'hFFFF_8000_0000_0001, 1'b1, 4'd3, 64'h0000_0000_FFFF_8000},
        {4'd3, 64'h0000_0000_0000_0000, 1'b1, 4'd2, 64'h0000_0000_0000_0001}
    };

    // Write in one cycle; flush_req is sampled in the following cycle.
    task automatic bus_write(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [3:0] a, input logic [63:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 7; a++) read_check("R1 reset read", 4'(a), 64'h0);
        check("R1 mmu_en", 64'(mmu_en), 64'h0);
        check("R1 flush_req", 64'(flush_req), 64'h0);
        check("R1 wr_err", 64'(wr_err), 64'h0);

        // R3 R4 R5 R6 R7 R8 vector table
        for (int i = 0; i < NV; i++) begin
            logic [136:0] v;
            v = VEC[i];
            bus_write(v[136:133], v[132:69]);
            check($sformatf("R3/R4/R7 flush vec %0d", i), 64'(flush_req), 64'(v[68]));
            read_check($sformatf("R5/R6 read vec %0d", i), v[67:64], v[63:0]);
            if (i == 8) begin
                check("R8 half0_size", 64'(half0_size), 64'h10);
                check("R8 half1_size", 64'(half1_size), 64'h19);
            end
            if (i == 7) begin
                check("R2 mmu_en", 64'(mmu_en), 64'h1);
                check("R2 user_kernel_ctl", 64'(user_kernel_ctl), 64'h1);
            end
        end

        // R2 disable clears only bit 0 and does not flush
        @(negedge clk); disable_req = 1'b1;
        @(negedge clk); disable_req = 1'b0;
        check("R2 flush after disable", 64'(flush_req), 64'h0);
        check("R2 mmu_en after disable", 64'(mmu_en), 64'h0);
        read_check("R2 ctrl after disable", A_CTRL, 64'h2);

        // R9 illegal bus write flag and walker load
        bus_write(A_FAULT, 64'hDEAD);
        check("R9 wr_err pulse", 64'(wr_err), 64'h1);
        read_check("R9 fault unchanged", A_FAULT, 64'h0);
        @(negedge clk);
        check("R9 wr_err single", 64'(wr_err), 64'h0);
        walker_fault_we = 1'b1; walker_fault_data = 64'h3;
        @(negedge clk); walker_fault_we = 1'b0;
        read_check("R9 walker load", A_FAULT, 64'h3);

        // R10 back-to-back triggering writes
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_ROOT0; reg_wdata = 64'h1111;
        @(negedge clk);
        reg_wdata = 64'h2222;
        check("R10 first flush", 64'(flush_req), 64'h1);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R10 second flush", 64'(flush_req), 64'h1);
        @(negedge clk);
        check("R10 flush ends", 64'(flush_req), 64'h0);
        check("R3 root0 output", root0_ptr, 64'h2222);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule